// File: doc/BRIEF.md
# Nine-Bit Multidrop Bus Peripheral Node

This block is a serial node for a shared bus whose characters are nine bits long: eight data bits and a mode bit. Every address character the master sends (mode bit 1) is checked by the node against its programmed address. A match selects the node, and the data characters that follow (mode bit 0) are passed to the local logic. A non-matching address deselects the node, and the data characters after it are dropped. The receiver runs on a 16x oversampling tick and flags a character whose stop bit is sampled low.

In the other direction, the local logic hands over response bytes one at a time. Each byte goes out with mode bit 0. When a byte is marked as the last of the response, the node adds one more character of its own: an 8-bit checksum with mode bit 1, which ends the message.

Top module: `mdb_node`

## Requirements
- R1: Each character on both lines is one low start bit, eight data bits with the least significant bit first, the mode bit, and one high stop bit. Each bit lasts OVS ticks, and a tick occurs once every TICK_DIV clock cycles.
- R2: A received character with mode bit 1 whose data equals `node_addr_i` selects the node. It is presented as a one-cycle `rx_valid_o` pulse with `rx_mode_o` = 1 and `rx_data_o` equal to the address.
- R3: While the node is selected, each received character with mode bit 0 is presented as a one-cycle `rx_valid_o` pulse with `rx_mode_o` = 0 and its data on `rx_data_o`.
- R4: A received character with mode bit 1 that does not equal `node_addr_i` deselects the node and produces no `rx_valid_o`. The data characters after it produce no `rx_valid_o`.
- R5: After reset the node is not selected. Data characters received before a matching address produce no `rx_valid_o`.
- R6: A character whose stop bit is sampled low produces a one-cycle `frame_err_o` pulse and no `rx_valid_o`, and it leaves the selection unchanged.
- R7: `tx_ready_o` is high while the transmitter is idle. A byte is taken when `tx_valid_i` and `tx_ready_o` are both high, and it is sent with mode bit 0. `tx_ready_o` stays low until the whole response has been sent.
- R8: After a byte taken with `tx_last_i` = 1, the node sends one more character with mode bit 1. Its data is the sum, modulo 256, of all bytes taken since the previous last byte (or since reset), including this one. The sum then restarts from zero.
- R9: During and right after reset, `tx_o` is high, `tx_ready_o` is high, and `rx_valid_o` and `frame_err_o` are low. `tx_o` stays high whenever the transmitter is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line from the master |
| node_addr_i | input | 8 | Programmed address of this node |
| rx_valid_o | output | 1 | One-cycle strobe for a delivered character |
| rx_data_o | output | 8 | Data of the delivered character |
| rx_mode_o | output | 1 | Mode bit of the delivered character |
| frame_err_o | output | 1 | One-cycle strobe when a stop bit is sampled low |
| tx_data_i | input | 8 | Response byte |
| tx_valid_i | input | 1 | Response byte is offered |
| tx_last_i | input | 1 | Offered byte is the last of the response |
| tx_ready_o | output | 1 | Transmitter is idle and can take a byte |
| tx_o | output | 1 | Serial line to the master |

## Verification
A wrong selection state shows up on the first data character after the address that should have changed it. That character is either delivered when it should be dropped, or dropped when it should be delivered, about one stop-bit midpoint after the character begins. A receiver that samples at the wrong moment corrupts `rx_data_o` on that same strobe. A bad checksum register shows up only on the closing character of a response. For that reason, the responses include a sum that wraps past 255 and a second response that exposes any sum left over from the first.

// File: rtl/mdb_pkg.sv
package mdb_pkg;
  localparam int DW = 8;          // data bits per character
  localparam int FW = DW + 3;     // start + data + mode + stop

  // Address comparison used by the filter; the bench restates it as plain equality.
  function automatic logic addr_hit(input logic [DW-1:0] ch, input logic [DW-1:0] own);
    return ch == own;
  endfunction

  // Running checksum step: modulo-256 addition.
  function automatic logic [DW-1:0] csum_add(input logic [DW-1:0] acc, input logic [DW-1:0] b);
    return acc + b;
  endfunction

  // Line image of one character, bit 0 leaves first.
  function automatic logic [FW-1:0] frame_pack(input logic mode, input logic [DW-1:0] d);
    return {1'b1, mode, d, 1'b0};
  endfunction
endpackage

// File: rtl/mdb_tick.sv
module mdb_tick #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdb_rx.sv
module mdb_rx
  import mdb_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_s,
  output logic          char_stb,
  output logic [DW-1:0] char_data,
  output logic          char_mode,
  output logic          char_ferr
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(OVS / 2 - 1);
  localparam logic [3:0] LAST_BIT = 4'(DW);   // index of the mode bit

  typedef enum logic [2:0] {S_IDLE, S_START, S_BITS, S_STOP, S_BREAK} rx_st_t;

  rx_st_t           st;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       bidx;
  logic [DW:0]      shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      bidx      <= '0;
      shreg     <= '0;
      char_stb  <= 1'b0;
      char_data <= '0;
      char_mode <= 1'b0;
      char_ferr <= 1'b0;
    end else begin
      char_stb <= 1'b0;
      unique case (st)
        S_IDLE: if (tick && !rx_s) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (tick) begin
          if (rx_s) st <= S_IDLE;               // glitch, not a start bit
          else if (cnt == HALF) begin
            st   <= S_BITS;
            cnt  <= '0;
            bidx <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_BITS: if (tick) begin
          if (cnt == FULL) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[DW:1]};
            if (bidx == LAST_BIT) st <= S_STOP;
            else bidx <= bidx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: if (tick) begin
          if (cnt == FULL) begin
            cnt       <= '0;
            char_stb  <= 1'b1;
            char_data <= shreg[DW-1:0];
            char_mode <= shreg[DW];
            char_ferr <= !rx_s;
            st        <= rx_s ? S_IDLE : S_BREAK;
          end else cnt <= cnt + 1'b1;
        end
        S_BREAK: if (rx_s) st <= S_IDLE;        // wait for the line to recover
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdb_filter.sv
module mdb_filter
  import mdb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_stb,
  input  logic [DW-1:0] char_data,
  input  logic          char_mode,
  input  logic          char_ferr,
  input  logic [DW-1:0] own_addr,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_mode,
  output logic          ferr_stb,
  output logic          selected
);
  logic good_char, hit;
  assign good_char = char_stb && !char_ferr;
  assign hit       = addr_hit(char_data, own_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selected  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_mode  <= 1'b0;
      ferr_stb  <= 1'b0;
    end else begin
      ferr_stb  <= char_stb && char_ferr;
      out_valid <= 1'b0;
      if (good_char) begin
        if (char_mode) begin
          selected  <= hit;
          out_valid <= hit;
        end else begin
          out_valid <= selected;
        end
        out_data <= char_data;
        out_mode <= char_mode;
      end
    end
  end
endmodule

// File: rtl/mdb_tx.sv
module mdb_tx
  import mdb_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_last,
  output logic          in_ready,
  output logic          line_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(OVS - 1);
  localparam int NB_W = $clog2(FW + 1);

  logic [FW-1:0]    shreg;
  logic [CNT_W-1:0] cnt;
  logic [NB_W-1:0]  nleft;
  logic             busy, ck_pend;
  logic [DW-1:0]    sum, ck_val;
  logic             take;

  assign take     = in_valid && !busy;
  assign in_ready = !busy;
  assign line_o   = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '1;
      cnt     <= '0;
      nleft   <= '0;
      busy    <= 1'b0;
      ck_pend <= 1'b0;
      sum     <= '0;
      ck_val  <= '0;
    end else if (take) begin
      shreg   <= frame_pack(1'b0, in_data);
      ck_val  <= csum_add(sum, in_data);
      sum     <= in_last ? '0 : csum_add(sum, in_data);
      ck_pend <= in_last;
      busy    <= 1'b1;
      cnt     <= '0;
      nleft   <= NB_W'(FW);
    end else if (busy && tick) begin
      if (cnt == FULL) begin
        cnt   <= '0;
        shreg <= {1'b1, shreg[FW-1:1]};
        if (nleft == NB_W'(1)) begin
          if (ck_pend) begin
            shreg   <= frame_pack(1'b1, ck_val);
            ck_pend <= 1'b0;
            nleft   <= NB_W'(FW);
          end else begin
            busy <= 1'b0;
          end
        end else nleft <= nleft - 1'b1;
      end else cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdb_node.sv
module mdb_node
  import mdb_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int TICK_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_i,
  input  logic [DW-1:0] node_addr_i,
  output logic          rx_valid_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_mode_o,
  output logic          frame_err_o,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_valid_i,
  input  logic          tx_last_i,
  output logic          tx_ready_o,
  output logic          tx_o
);
  logic          tick;
  logic          rx_meta, rx_s;
  logic          ch_stb, ch_mode, ch_ferr;
  logic [DW-1:0] ch_data;
  logic          node_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= rx_i;
      rx_s    <= rx_meta;
    end
  end

  mdb_tick #(.TICK_DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  mdb_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s),
    .char_stb(ch_stb), .char_data(ch_data), .char_mode(ch_mode), .char_ferr(ch_ferr)
  );

  mdb_filter u_filt (
    .clk(clk), .rst_n(rst_n),
    .char_stb(ch_stb), .char_data(ch_data), .char_mode(ch_mode), .char_ferr(ch_ferr),
    .own_addr(node_addr_i),
    .out_valid(rx_valid_o), .out_data(rx_data_o), .out_mode(rx_mode_o),
    .ferr_stb(frame_err_o), .selected(node_sel)
  );

  mdb_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .in_data(tx_data_i), .in_valid(tx_valid_i), .in_last(tx_last_i),
    .in_ready(tx_ready_o), .line_o(tx_o)
  );
endmodule

// File: rtl/mdb_node_chk.sv
module mdb_node_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid_o,
  input logic       rx_mode_o,
  input logic [7:0] rx_data_o,
  input logic [7:0] node_addr_i,
  input logic       frame_err_o,
  input logic       node_sel,
  input logic       tx_ready_o,
  input logic       tx_valid_i,
  input logic       tx_o
);
  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  a_r6_ferr_drops_char: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |-> !rx_valid_o);

  a_r4_data_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_mode_o) |-> node_sel);

  a_r2_addr_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && rx_mode_o) |-> (node_sel && rx_data_o == node_addr_i));

  a_r7_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready_o && tx_valid_i) |=> !tx_ready_o);

  a_r9_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> tx_o);
endmodule

bind mdb_node mdb_node_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .rx_valid_o(rx_valid_o), .rx_mode_o(rx_mode_o), .rx_data_o(rx_data_o),
  .node_addr_i(node_addr_i), .frame_err_o(frame_err_o), .node_sel(node_sel),
  .tx_ready_o(tx_ready_o), .tx_valid_i(tx_valid_i), .tx_o(tx_o)
);

// File: tb/tb_mdb_node.sv
module tb_mdb_node;
  localparam int OVS = 16;
  localparam int TD  = 4;
  localparam int BIT = OVS * TD;            // R1: clocks per bit
  localparam logic [7:0] ADDR = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_i = 1'b1;
  logic       rx_valid_o, rx_mode_o, frame_err_o, tx_ready_o, tx_o;
  logic [7:0] rx_data_o;
  logic [7:0] tx_data_i = '0;
  logic       tx_valid_i = 1'b0, tx_last_i = 1'b0;

  int checks = 0, fails = 0;
  int rx_cnt = 0, ferr_cnt = 0;
  logic [7:0] last_data = '0;
  logic       last_mode = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  mdb_node #(.OVS(OVS), .TICK_DIV(TD)) dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .node_addr_i(ADDR),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .rx_mode_o(rx_mode_o),
    .frame_err_o(frame_err_o), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_last_i(tx_last_i), .tx_ready_o(tx_ready_o), .tx_o(tx_o)
  );

  always @(negedge clk) begin
    if (rx_valid_o) begin
      rx_cnt    = rx_cnt + 1;
      last_data = rx_data_o;
      last_mode = rx_mode_o;
    end
    if (frame_err_o) ferr_cnt = ferr_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1: drive one character onto rx_i, optionally with a low stop bit.
  task automatic send_char(input logic mode, input logic [7:0] d, input logic bad_stop);
    rx_i = 1'b0; wait_clk(BIT);
    for (int i = 0; i < 8; i++) begin rx_i = d[i]; wait_clk(BIT); end
    rx_i = mode;      wait_clk(BIT);
    rx_i = !bad_stop; wait_clk(BIT);
    rx_i = 1'b1;      wait_clk(2 * BIT);
  endtask

  // R1: decode one character from tx_o at bit centres.
  task automatic grab_char(output logic [7:0] d, output logic mode, output logic framing_ok);
    int guard = 0;
    while (tx_o !== 1'b0 && guard < 40 * BIT) begin @(negedge clk); guard++; end
    wait_clk(BIT / 2);
    framing_ok = (tx_o == 1'b0);
    for (int i = 0; i < 8; i++) begin wait_clk(BIT); d[i] = tx_o; end
    wait_clk(BIT); mode = tx_o;
    wait_clk(BIT); framing_ok = framing_ok && (tx_o == 1'b1);
  endtask

  task automatic offer(input logic [7:0] d, input logic last);
    while (!tx_ready_o) @(negedge clk);
    tx_data_i = d; tx_last_i = last; tx_valid_i = 1'b1;
    @(negedge clk);
    tx_valid_i = 1'b0; tx_last_i = 1'b0;
  endtask

  task automatic expect_tx(input logic [7:0] ed, input logic em, input string req);
    logic [7:0] d; logic m, fok;
    grab_char(d, m, fok);
    check(fok && d == ed && m == em, req, {fok, m, d}, {1'b1, em, ed});
  endtask

  // {req, inject bad stop, mode, expect valid, expect mode, data}
  localparam logic [15:0] VEC [11] = '{
    {4'd5, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11},   // R5 data before any address
    {4'd2, 1'b0, 1'b1, 1'b1, 1'b1, ADDR },   // R2 own address
    {4'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'h33},   // R3
    {4'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF},   // R3
    {4'd4, 1'b0, 1'b1, 1'b0, 1'b0, 8'h20},   // R4 other address
    {4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'h44},   // R4 dropped
    {4'd2, 1'b0, 1'b1, 1'b1, 1'b1, ADDR },   // R2 reselect
    {4'd6, 1'b1, 1'b0, 1'b0, 1'b0, 8'h77},   // R6 low stop bit
    {4'd6, 1'b0, 1'b0, 1'b1, 1'b0, 8'h88},   // R6 still selected
    {4'd4, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5},   // R4 bit-inverted address
    {4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}    // R4 dropped
  };

  initial begin
    wait_clk(5);
    // R9 reset state
    check(tx_o == 1'b1, "R9 tx idle", tx_o, 1);
    check(tx_ready_o == 1'b1, "R9 ready", tx_ready_o, 1);
    check(rx_valid_o == 1'b0 && frame_err_o == 1'b0, "R9 strobes", {rx_valid_o, frame_err_o}, 0);
    rst_n = 1'b1;
    wait_clk(3 * BIT);
    check(tx_o == 1'b1 && rx_cnt == 0, "R9 idle after reset", {tx_o, rx_cnt[3:0]}, 5'h10);

    for (int k = 0; k < 11; k++) begin
      automatic logic [15:0] v = VEC[k];
      automatic int c0 = rx_cnt, f0 = ferr_cnt;
      automatic string tag = $sformatf("R%0d vector %0d", v[15:12], k);
      send_char(v[10], v[7:0], v[11]);
      check((rx_cnt - c0) == int'(v[9]), tag, rx_cnt - c0, v[9]);
      if (v[9]) check(last_data == v[7:0] && last_mode == v[8], tag,
                      {last_mode, last_data}, {v[8], v[7:0]});
      check((ferr_cnt - f0) == int'(v[11]), tag, ferr_cnt - f0, v[11]);
    end

    // R7 R8: 0x10 + 0x20 -> checksum 0x30
    fork
      begin offer(8'h10, 1'b0); offer(8'h20, 1'b1); end
      begin
        expect_tx(8'h10, 1'b0, "R7 first byte");
        expect_tx(8'h20, 1'b0, "R7 last byte mode 0");
        expect_tx(8'h30, 1'b1, "R8 checksum");
      end
    join
    wait_clk(2 * BIT);
    check(tx_ready_o == 1'b1 && tx_o == 1'b1, "R7 ready after response", {tx_ready_o, tx_o}, 3);

    // R8: wrap past 255 and sum restarted: 0xF0 + 0x20 -> 0x10
    fork
      begin offer(8'hF0, 1'b0); offer(8'h20, 1'b1); end
      begin
        expect_tx(8'hF0, 1'b0, "R8 byte a");
        expect_tx(8'h20, 1'b0, "R8 byte b");
        expect_tx(8'h10, 1'b1, "R8 wrapped checksum");
      end
    join

    // R8: single-byte response, checksum equals the byte
    fork
      offer(8'hC3, 1'b1);
      begin
        expect_tx(8'hC3, 1'b0, "R8 single byte");
        expect_tx(8'hC3, 1'b1, "R8 single checksum");
      end
    join

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule